// File: doc/BRIEF.md
# Bus-Sampled Fault Register

This block collects error indications from the system bus and from two asynchronous fault lines into one 16-bit sticky register. Three active-low bus error inputs (memory protection, memory parity, external address) are captured once per bus cycle, at the moment the active-low busy line returns high. The capture covers every bus cycle, whichever master owns it. Two flags that travel with the cycle steer the capture. The ownership flag separates protection errors of this CPU from those of other masters. The memory/I/O flag separates address errors on memory cycles from those on I/O cycles.

The two asynchronous fault lines pass through a synchronizer and set their bits on a rising edge only. Software reads the register at `flt_q` and clears it by writing a mask of ones. A registered summary output is high whenever any bit is set.

Bits are numbered in the bus convention: register bit 0 is the most significant bit of `flt_q`, so register bit k appears at `flt_q[15-k]`.

Top module: `fault_capture_reg`

## Requirements
- R1: A synchronous active-high reset clears all 16 register bits and drives `flt_any` low.
- R2: Register bit k is presented at `flt_q[15-k]`, so register bit 0 is `flt_q[15]`.
- R3: The bus error inputs are taken only when `busy_n` goes from low to high. The values used are those present at the last clock on which `busy_n` was still low. Errors shown while `busy_n` stays low, or while the bus is idle, set nothing.
- R4: A protection error (`prot_err_n` low) sets register bit 0 when `cyc_own` is 1 (cycle owned by this CPU) and register bit 1 when `cyc_own` is 0.
- R5: A parity error (`par_err_n` low) sets register bit 2, whoever owns the cycle.
- R6: An address error (`addr_err_n` low) sets register bit 5 when `cyc_mem` is 1 (memory cycle) and register bit 8 when `cyc_mem` is 0 (I/O cycle).
- R7: A rising edge on `sys_flt0` sets register bit 7. Holding the line high sets the bit once only, so a clear made while the line stays high holds.
- R8: A rising edge on `sys_flt1` sets register bits 13 and 15 together.
- R9: Bits are sticky. With `clr_we` high, every bit whose `clr_mask` bit is 1 is cleared and all other bits keep their value. With `clr_we` low, `clr_mask` has no effect.
- R10: When a bit is set and cleared in the same clock, it ends up set.
- R11: `flt_any` is the OR of all register bits and changes in the same cycle as `flt_q`.
- R12: A bus fault appears two clocks after the first clock at which `busy_n` is sampled high. With the default two synchronizer stages, a system fault appears three clocks after the first clock at which its line is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy_n | input | 1 | Bus busy, active low; its rising edge ends a bus cycle |
| cyc_own | input | 1 | 1 when this CPU owns the current bus cycle |
| cyc_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| prot_err_n | input | 1 | Memory protection error, active low |
| par_err_n | input | 1 | Memory parity error, active low |
| addr_err_n | input | 1 | External address error, active low |
| sys_flt0 | input | 1 | Asynchronous system fault 0, rising-edge sensitive |
| sys_flt1 | input | 1 | Asynchronous system fault 1, rising-edge sensitive |
| clr_we | input | 1 | Clear strobe |
| clr_mask | input | 16 | Write-one-to-clear mask, in the same bit order as `flt_q` |
| flt_q | output | 16 | Fault register, register bit 0 at index 15 |
| flt_any | output | 1 | High when any register bit is set |

## Verification
The hardest case to reach is a new fault and a software clear landing in the same clock. The bench times this from the end of the bus cycle. It raises `busy_n`, waits exactly one clock, and then applies a full clear mask so that the clear meets the commit edge of a parity fault. A bit set beforehand shows that the clear took effect on every other bit.

Several other cases are also hard to reach from the ports. These are an error that is withdrawn before the last low clock of a cycle, an error shown only while the bus is idle, and a system fault line held high across a clear. Each is driven at a clock-exact position and checked for no effect. All 32 combinations of the three bus errors with the ownership and memory/I/O flags are swept, and the expected bits are computed from the bit-position rules.

// File: rtl/fltreg_pkg.sv
package fltreg_pkg;
  localparam int FLT_W   = 16;
  localparam int NUM_SYS = 2;

  // register bit numbers (bit 0 = most significant)
  localparam int B_PROT_OWN = 0;
  localparam int B_PROT_OTH = 1;
  localparam int B_PARITY   = 2;
  localparam int B_ADDR_MEM = 5;
  localparam int B_SYS0     = 7;
  localparam int B_ADDR_IO  = 8;
  localparam int B_SYS1_A   = 13;
  localparam int B_SYS1_B   = 15;

  // vector indices derived from register bit numbers
  localparam int V_PROT_OWN = FLT_W - 1 - B_PROT_OWN;
  localparam int V_PROT_OTH = FLT_W - 1 - B_PROT_OTH;
  localparam int V_PARITY   = FLT_W - 1 - B_PARITY;
  localparam int V_ADDR_MEM = FLT_W - 1 - B_ADDR_MEM;
  localparam int V_SYS0     = FLT_W - 1 - B_SYS0;
  localparam int V_ADDR_IO  = FLT_W - 1 - B_ADDR_IO;
  localparam int V_SYS1_A   = FLT_W - 1 - B_SYS1_A;
  localparam int V_SYS1_B   = FLT_W - 1 - B_SYS1_B;

  typedef struct packed {
    logic prot;
    logic par;
    logic addr;
    logic own;
    logic mem;
  } bus_smp_t;
endpackage

// File: rtl/flt_sync_edge.sv
module flt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SH_W-2:0], d};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/flt_bus_sampler.sv
module flt_bus_sampler
  import fltreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_n,
  input  logic             cyc_own,
  input  logic             cyc_mem,
  input  logic             prot_err_n,
  input  logic             par_err_n,
  input  logic             addr_err_n,
  output logic [FLT_W-1:0] bus_set
);
  bus_smp_t cur, prv;
  logic     b1, b2;
  logic     trail;

  always_ff @(posedge clk) begin
    if (rst) begin
      b1  <= 1'b1;
      b2  <= 1'b1;
      cur <= '0;
      prv <= '0;
    end else begin
      b1  <= busy_n;
      b2  <= b1;
      cur <= {~prot_err_n, ~par_err_n, ~addr_err_n, cyc_own, cyc_mem};
      prv <= cur;
    end
  end

  assign trail = b1 & ~b2;

  always_comb begin
    bus_set = '0;
    if (trail) begin
      if (prv.prot) begin
        if (prv.own) bus_set[V_PROT_OWN] = 1'b1;
        else         bus_set[V_PROT_OTH] = 1'b1;
      end
      if (prv.par) bus_set[V_PARITY] = 1'b1;
      if (prv.addr) begin
        if (prv.mem) bus_set[V_ADDR_MEM] = 1'b1;
        else         bus_set[V_ADDR_IO]  = 1'b1;
      end
    end
  end

  // R3
  trail_only_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_set != '0) |-> ($past(busy_n) && !$past(busy_n, 2)));

  // R4
  prot_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_set[V_PROT_OWN] && bus_set[V_PROT_OTH]));

  // R6
  addr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_set[V_ADDR_MEM] && bus_set[V_ADDR_IO]));
endmodule

// File: rtl/flt_store.sv
module flt_store
  import fltreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [FLT_W-1:0] set_vec,
  input  logic             clr_we,
  input  logic [FLT_W-1:0] clr_mask,
  output logic [FLT_W-1:0] flt_q,
  output logic             flt_any
);
  logic [FLT_W-1:0] clr_eff, nxt;

  assign clr_eff = clr_we ? clr_mask : '0;
  assign nxt     = (flt_q & ~clr_eff) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q   <= '0;
      flt_any <= 1'b0;
    end else begin
      flt_q   <= nxt;
      flt_any <= |nxt;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (flt_q == '0 && !flt_any));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(flt_q) & ~($past(clr_we) ? $past(clr_mask) : '0)) & ~flt_q) == '0));

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_vec) & ~flt_q) == '0));

  // R11
  summary_chk: assert property (@(posedge clk) disable iff (rst)
    flt_any == (|flt_q));
endmodule

// File: rtl/fault_capture_reg.sv
module fault_capture_reg
  import fltreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_n,
  input  logic             cyc_own,
  input  logic             cyc_mem,
  input  logic             prot_err_n,
  input  logic             par_err_n,
  input  logic             addr_err_n,
  input  logic             sys_flt0,
  input  logic             sys_flt1,
  input  logic             clr_we,
  input  logic [FLT_W-1:0] clr_mask,
  output logic [FLT_W-1:0] flt_q,
  output logic             flt_any
);
  logic [FLT_W-1:0]   bus_set, sys_set, set_vec;
  logic [NUM_SYS-1:0] sys_in, sys_rise;

  assign sys_in = {sys_flt1, sys_flt0};

  flt_bus_sampler u_bus (
    .clk(clk), .rst(rst), .busy_n(busy_n), .cyc_own(cyc_own), .cyc_mem(cyc_mem),
    .prot_err_n(prot_err_n), .par_err_n(par_err_n), .addr_err_n(addr_err_n),
    .bus_set(bus_set)
  );

  for (genvar g = 0; g < NUM_SYS; g++) begin : g_sys
    flt_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .d(sys_in[g]), .rise(sys_rise[g])
    );
  end

  always_comb begin
    sys_set = '0;
    sys_set[V_SYS0]   = sys_rise[0];
    sys_set[V_SYS1_A] = sys_rise[1];
    sys_set[V_SYS1_B] = sys_rise[1];
  end

  assign set_vec = bus_set | sys_set;

  flt_store u_store (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_we(clr_we), .clr_mask(clr_mask),
    .flt_q(flt_q), .flt_any(flt_any)
  );
endmodule

// File: tb/sim_fault_capture_reg.sv
module sim_fault_capture_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst, busy_n, cyc_own, cyc_mem, prot_err_n, par_err_n, addr_err_n;
  logic sys_flt0, sys_flt1, clr_we;
  logic [15:0] clr_mask, flt_q;
  logic flt_any;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_capture_reg u0 (
    .clk(clk), .rst(rst), .busy_n(busy_n), .cyc_own(cyc_own), .cyc_mem(cyc_mem),
    .prot_err_n(prot_err_n), .par_err_n(par_err_n), .addr_err_n(addr_err_n),
    .sys_flt0(sys_flt0), .sys_flt1(sys_flt1), .clr_we(clr_we), .clr_mask(clr_mask),
    .flt_q(flt_q), .flt_any(flt_any)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] pos(input int b);
    return 16'h8000 >> b;
  endfunction

  function automatic logic [15:0] exp_bus(input logic pe, pa, ae, ow, me);
    logic [15:0] e = '0;
    if (pe) e |= ow ? pos(0) : pos(1);
    if (pa) e |= pos(2);
    if (ae) e |= me ? pos(5) : pos(8);
    return e;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_both(input string tag, input logic [15:0] exp);
    chk(tag, flt_q, exp);
    chk({tag, " R11 any"}, {15'd0, flt_any}, {15'd0, exp != 16'd0});
  endtask

  // drive errors during a low phase of lowlen clocks; raise busy at the end
  task automatic bus_low(input logic pe, pa, ae, ow, me, input int lowlen);
    @(negedge clk);
    busy_n = 1'b0; cyc_own = ow; cyc_mem = me;
    prot_err_n = ~pe; par_err_n = ~pa; addr_err_n = ~ae;
    repeat (lowlen) @(negedge clk);
    busy_n = 1'b1; prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
  endtask

  task automatic do_clear(input logic [15:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    rst = 1'b1; busy_n = 1'b1; cyc_own = 1'b1; cyc_mem = 1'b1;
    prot_err_n = 1'b1; par_err_n = 1'b1; addr_err_n = 1'b1;
    sys_flt0 = 1'b0; sys_flt1 = 1'b0; clr_we = 1'b0; clr_mask = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_both("R1 reset", 16'h0000);

    // R2: own-cycle protection error lands in the MSB
    bus_low(1, 0, 0, 1, 1, 3);
    @(negedge clk);
    chk("R12 not yet", flt_q, 16'h0000);
    @(negedge clk);
    chk("R2 msb", flt_q, 16'h8000);
    do_clear(16'hFFFF);
    chk_both("R9 clear all", 16'h0000);

    // R4 R5 R6: sweep all combinations
    for (int i = 0; i < 32; i++) begin
      logic pe, pa, ae, ow, me;
      pe = i[0]; pa = i[1]; ae = i[2]; ow = i[3]; me = i[4];
      bus_low(pe, pa, ae, ow, me, 2);
      repeat (2) @(negedge clk);
      chk_both($sformatf("R4 R5 R6 sweep %0d", i), exp_bus(pe, pa, ae, ow, me));
      do_clear(16'hFFFF);
    end

    // R3: errors while still low set nothing yet
    @(negedge clk);
    busy_n = 1'b0; par_err_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 low hold", flt_q, 16'h0000);
    busy_n = 1'b1; par_err_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 trailing", flt_q, pos(2));
    do_clear(16'hFFFF);

    // R3: errors during idle only
    @(negedge clk);
    prot_err_n = 1'b0; addr_err_n = 1'b0;
    repeat (4) @(negedge clk);
    prot_err_n = 1'b1; addr_err_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 idle", flt_q, 16'h0000);

    // R3: error withdrawn before the last low clock
    @(negedge clk);
    busy_n = 1'b0; addr_err_n = 1'b0; cyc_mem = 1'b1;
    repeat (2) @(negedge clk);
    addr_err_n = 1'b1;
    @(negedge clk);
    busy_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 withdrawn", flt_q, 16'h0000);

    // R7: system fault 0 edge and latency
    @(negedge clk);
    sys_flt0 = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 sys not yet", flt_q, 16'h0000);
    @(negedge clk);
    chk_both("R7 sys0", pos(7));
    do_clear(pos(7));
    repeat (5) @(negedge clk);
    chk("R7 level no reset", flt_q, 16'h0000);
    sys_flt0 = 1'b0;

    // R8: system fault 1
    @(negedge clk);
    sys_flt1 = 1'b1;
    repeat (3) @(negedge clk);
    chk_both("R8 sys1", pos(13) | pos(15));
    sys_flt1 = 1'b0;

    // R9: partial clear and ignored mask
    bus_low(1, 1, 1, 0, 0, 2);
    repeat (2) @(negedge clk);
    chk("R9 setup", flt_q, pos(1) | pos(2) | pos(8) | pos(13) | pos(15));
    @(negedge clk);
    clr_mask = 16'hFFFF;
    @(negedge clk);
    clr_mask = '0;
    chk("R9 mask without strobe", flt_q, pos(1) | pos(2) | pos(8) | pos(13) | pos(15));
    do_clear(pos(2) | pos(13));
    chk("R9 partial", flt_q, pos(1) | pos(8) | pos(15));
    do_clear(16'hFFFF);

    // R10: set and clear in the same clock
    @(negedge clk);
    sys_flt0 = 1'b1;
    repeat (3) @(negedge clk);
    sys_flt0 = 1'b0;
    bus_low(0, 1, 0, 1, 1, 2);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = 16'hFFFF;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    chk_both("R10 set wins", pos(2));

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_both("R1 mid reset", 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule